// File: doc/BRIEF.md
# Lane Block-Striping Serializer

This block moves one wide parallel word of a lane across a group of single-bit I/O lines. The word is cut into equal, contiguous blocks. Block k travels on I/O k, one bit per unit interval, least significant bit first. A block is 8 bits by default. A 10-bit block can be selected for high-bandwidth operation, as though the two link partners had agreed on it. The parallel side uses a valid/ready handshake. The transmitter accepts a new word in the last bit cycle of the word it is sending, so words go out back to back with no idle gap.

A matching deserializer on the receive side rebuilds the word. The transmitter marks the first bit interval of every word with a start strobe. Alongside the start strobe it drives a length flag, so the receiver knows where each block begins and how long it is. The block-length setting is captured only when a word is accepted. A change therefore takes effect at a word boundary and never splits a block. While no word is in flight, every line is held low.

Top module: `bsl_lane_link`

## Requirements
- R1: While reset is held and just after it, `in_ready` is 1, and `io_tx`, `io_sof`, `io_long`, `out_valid` and `out_data` are all 0.
- R2: A word is accepted at a rising edge where both `in_valid` and `in_ready` are 1. In the B clock cycles after that edge, `io_tx[k]` carries the word's bits k*B up to k*B+B-1 in turn, starting with bit k*B. B is the block length.
- R3: `io_sof` is 1 only in the first bit cycle of each word. `io_long` stays constant for the whole word and is 1 exactly when B is 10.
- R4: B is 8 when `cfg_long` is 0 at the accepting edge, and 10 when it is 1. A word occupies exactly B cycles on the lines.
- R5: `cfg_long` is sampled only at the accepting edge. Changes to it while a word is in flight do not alter that word's block length or bits.
- R6: `in_ready` is 1 when the transmitter is idle or in the last bit cycle of a word, and 0 otherwise. A word offered in that last cycle starts in the very next cycle, with no gap.
- R7: When no word is in flight, all `io_tx` lines, `io_sof` and `io_long` are 0, and `in_ready` is 1.
- R8: With the lines looped back to the receiver, `out_valid` pulses for one cycle, B+1 cycles after the accepting edge. In that cycle `out_data` equals the sent word. With 8-bit blocks, `out_data` bits at positions 8*NIO and above are 0, whatever those bits held at the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one unit interval per cycle |
| rst_n | input | 1 | Active-low reset |
| cfg_long | input | 1 | Block length select: 0 = 8 bits, 1 = 10 bits |
| in_valid | input | 1 | Parallel word offered |
| in_ready | output | 1 | Transmitter can accept a word this cycle |
| in_data | input | NIO*10 | Parallel word; only the low NIO*8 bits are used with 8-bit blocks |
| io_tx | output | NIO | Serial I/O lines, one block each |
| io_sof | output | 1 | High in the first bit cycle of a word |
| io_long | output | 1 | Block length of the word on the lines |
| io_rx | input | NIO | Serial I/O lines into the receiver |
| rx_sof | input | 1 | Start strobe into the receiver |
| rx_long | input | 1 | Length flag into the receiver |
| out_valid | output | 1 | One-cycle pulse when a rebuilt word is presented |
| out_data | output | NIO*10 | Rebuilt word, zero outside the `out_valid` cycle |

## Verification
The start strobe appears in the cycle right after the accepting edge. Bit j of every block follows j cycles later, so the bench counts falling edges from the strobe and compares each line against bit k*B+j of the queued word. The rebuilt word is due exactly B falling edges after the strobe was seen. The monitor stores that due count with each expected entry and flags both a late pulse and a missing pulse. Ready is checked every cycle against the bit index: it must be high only in the last bit cycle and while idle.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    typedef enum logic {
        BLK_SHORT = 1'b0,
        BLK_LONG  = 1'b1
    } blk_len_e;

endpackage

// File: rtl/bsl_tx_lane.sv
module bsl_tx_lane #(
    parameter int BL_S = 8,
    parameter int BL_L = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            long_m,
    input  logic [BL_L-1:0] blk_l,
    input  logic [BL_S-1:0] blk_s,
    output logic            bit_o
);

    localparam int PAD = BL_L - BL_S;

    typedef struct packed {
        logic [BL_L-1:0] sr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            if (long_m) st_d.sr = blk_l;
            else        st_d.sr = {{PAD{1'b0}}, blk_s};
        end else begin
            // drains with zeros, so an idle lane is low
            st_d.sr = {1'b0, st_q.sr[BL_L-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o = st_q.sr[0];

endmodule

// File: rtl/bsl_tx_ser.sv
module bsl_tx_ser
    import bsl_pkg::*;
#(
    parameter int NIO  = 38,
    parameter int BL_S = 8,
    parameter int BL_L = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_long,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [NIO*BL_L-1:0] in_data,
    output logic [NIO-1:0]    io_tx,
    output logic              io_sof,
    output logic              io_long,
    output logic              active
);

    localparam int CW = $clog2(BL_L + 1);
    localparam logic [CW-1:0] LAST_S = CW'(BL_S - 1);
    localparam logic [CW-1:0] LAST_L = CW'(BL_L - 1);

    typedef struct packed {
        logic            active;
        logic [CW-1:0]   cnt;
        blk_len_e        mode;
        logic            sof;
    } st_t;

    st_t  st_d, st_q;
    logic last_hit;
    logic load;

    always_comb begin
        last_hit = st_q.active &&
                   (st_q.cnt == ((st_q.mode == BLK_LONG) ? LAST_L : LAST_S));
        in_ready = !st_q.active || last_hit;
        load     = in_valid && in_ready;

        st_d = st_q;
        if (load) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.mode   = blk_len_e'(cfg_long);
            st_d.sof    = 1'b1;
        end else if (last_hit) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
            st_d.mode   = BLK_SHORT;
            st_d.sof    = 1'b0;
        end else if (st_q.active) begin
            st_d.cnt    = CW'(st_q.cnt + 1'b1);
            st_d.sof    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign io_sof  = st_q.sof;
    assign io_long = st_q.active && (st_q.mode == BLK_LONG);
    assign active  = st_q.active;

    for (genvar k = 0; k < NIO; k++) begin : g_lane
        bsl_tx_lane #(
            .BL_S (BL_S),
            .BL_L (BL_L)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (load),
            .long_m (cfg_long),
            .blk_l  (in_data[k*BL_L +: BL_L]),
            .blk_s  (in_data[k*BL_S +: BL_S]),
            .bit_o  (io_tx[k])
        );
    end

endmodule

// File: rtl/bsl_rx_lane.sv
module bsl_rx_lane #(
    parameter int BL_S = 8,
    parameter int BL_L = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            long_m,
    input  logic            bit_i,
    output logic [BL_L-1:0] blk_o
);

    localparam int PAD = BL_L - BL_S;

    typedef struct packed {
        logic [BL_L-1:0] sr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            // new bits enter at the top of the active block and move down
            if (long_m) st_d.sr = {bit_i, st_q.sr[BL_L-1:1]};
            else        st_d.sr = {{PAD{1'b0}}, bit_i, st_q.sr[BL_S-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blk_o = st_q.sr;

endmodule

// File: rtl/bsl_rx_des.sv
module bsl_rx_des
    import bsl_pkg::*;
#(
    parameter int NIO  = 38,
    parameter int BL_S = 8,
    parameter int BL_L = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NIO-1:0]      io_rx,
    input  logic                rx_sof,
    input  logic                rx_long,
    output logic                out_valid,
    output logic [NIO*BL_L-1:0] out_data
);

    localparam int CW = $clog2(BL_L + 1);
    localparam logic [CW-1:0] LAST_S = CW'(BL_S - 1);
    localparam logic [CW-1:0] LAST_L = CW'(BL_L - 1);

    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
        blk_len_e      mode;
        logic          valid;
    } st_t;

    st_t             st_d, st_q;
    logic            shift_en;
    logic            mode_now;
    logic            last_hit;
    logic [BL_L-1:0] lane_blk [NIO];

    always_comb begin
        shift_en = rx_sof || st_q.active;
        mode_now = rx_sof ? rx_long : (st_q.mode == BLK_LONG);
        last_hit = st_q.active &&
                   (st_q.cnt == ((st_q.mode == BLK_LONG) ? LAST_L : LAST_S));

        st_d       = st_q;
        st_d.valid = 1'b0;
        if (rx_sof) begin
            st_d.active = 1'b1;
            st_d.cnt    = CW'(1);
            st_d.mode   = blk_len_e'(rx_long);
        end else if (last_hit) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
            st_d.valid  = 1'b1;
        end else if (st_q.active) begin
            st_d.cnt    = CW'(st_q.cnt + 1'b1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < NIO; k++) begin : g_lane
        bsl_rx_lane #(
            .BL_S (BL_S),
            .BL_L (BL_L)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .long_m   (mode_now),
            .bit_i    (io_rx[k]),
            .blk_o    (lane_blk[k])
        );
    end

    always_comb begin
        out_data = '0;
        if (st_q.valid) begin
            for (int k = 0; k < NIO; k++) begin
                if (st_q.mode == BLK_LONG) out_data[k*BL_L +: BL_L] = lane_blk[k];
                else                       out_data[k*BL_S +: BL_S] = lane_blk[k][BL_S-1:0];
            end
        end
    end

    assign out_valid = st_q.valid;

endmodule

// File: rtl/bsl_lane_link.sv
module bsl_lane_link #(
    parameter int NIO  = 38,
    parameter int BL_S = 8,
    parameter int BL_L = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_long,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [NIO*BL_L-1:0] in_data,
    output logic [NIO-1:0]      io_tx,
    output logic                io_sof,
    output logic                io_long,
    input  logic [NIO-1:0]      io_rx,
    input  logic                rx_sof,
    input  logic                rx_long,
    output logic                out_valid,
    output logic [NIO*BL_L-1:0] out_data
);

    logic tx_active;

    bsl_tx_ser #(
        .NIO  (NIO),
        .BL_S (BL_S),
        .BL_L (BL_L)
    ) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_long (cfg_long),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .io_tx    (io_tx),
        .io_sof   (io_sof),
        .io_long  (io_long),
        .active   (tx_active)
    );

    bsl_rx_des #(
        .NIO  (NIO),
        .BL_S (BL_S),
        .BL_L (BL_L)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_rx     (io_rx),
        .rx_sof    (rx_sof),
        .rx_long   (rx_long),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/bsl_lane_chk.sv
module bsl_lane_chk #(
    parameter int NIO = 38
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           in_ready,
    input logic [NIO-1:0] io_tx,
    input logic           io_sof,
    input logic           io_long,
    input logic           out_valid,
    input logic           tx_active
);

    AST_LOAD_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> io_sof); // R2

    AST_SOF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        io_sof |=> !io_sof); // R3

    AST_LEN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && !io_sof) |-> $stable(io_long)); // R5

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> in_ready); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active |-> (io_tx == '0 && !io_sof && !io_long)); // R7

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R8

endmodule

bind bsl_lane_link bsl_lane_chk #(
    .NIO (NIO)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .io_tx     (io_tx),
    .io_sof    (io_sof),
    .io_long   (io_long),
    .out_valid (out_valid),
    .tx_active (tx_active)
);

// File: tb/test_bsl_lane_link.sv
`timescale 1ns/1ps
module test_bsl_lane_link;

    localparam int NIO  = 38;
    localparam int BL_S = 8;
    localparam int BL_L = 10;
    localparam int W    = NIO * BL_L;

    typedef struct {
        logic [W-1:0] d;
        logic         l10;
        int           due;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_long = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic [NIO-1:0] io_tx;
    logic         io_sof;
    logic         io_long;
    logic         out_valid;
    logic [W-1:0] out_data;

    int total = 0;
    int bad   = 0;
    int ncnt  = 0;

    item_t accq[$];
    item_t rxq[$];
    item_t cur;
    bit    act = 0;
    int    j   = 0;
    int    blen = 8;

    always #4 clk = ~clk;

    bsl_lane_link #(
        .NIO  (NIO),
        .BL_S (BL_S),
        .BL_L (BL_L)
    ) i_bsl_lane_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_long  (cfg_long),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .io_tx     (io_tx),
        .io_sof    (io_sof),
        .io_long   (io_long),
        .io_rx     (io_tx),
        .rx_sof    (io_sof),
        .rx_long   (io_long),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input bit ok, input string req, input logic [W-1:0] a, input logic [W-1:0] e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, a, e);
        end
    endtask

    function automatic logic [W-1:0] rnd_word();
        logic [W-1:0] v;
        for (int i = 0; i < W; i++) v[i] = 1'($urandom % 2);
        return v;
    endfunction

    function automatic logic [W-1:0] expect_word(logic [W-1:0] d, logic l10);
        logic [W-1:0] m;
        m = '0;
        for (int i = 0; i < NIO * BL_S; i++) m[i] = 1'b1;
        return l10 ? d : (d & m);
    endfunction

    // driver: offer a word, wait for the handshake, queue the expectation
    task automatic send(input logic [W-1:0] d, input logic l10);
        item_t it;
        bit ok;
        cfg_long = l10;
        in_data  = d;
        in_valid = 1'b1;
        do begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk);
            #1;
        end while (!ok);
        it.d   = d;
        it.l10 = l10;
        it.due = 0;
        accq.push_back(it);
        in_valid = 1'b0;
        in_data  = rnd_word();
    endtask

    // monitor: line-level and rebuilt-word scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            // receive side
            if (out_valid) begin
                if (rxq.size() == 0) begin
                    chk(1'b0, "R8 unexpected out_valid", W'(1), W'(0));
                end else begin
                    item_t e;
                    e = rxq.pop_front();
                    chk(ncnt == e.due, "R8 out_valid timing", W'(ncnt), W'(e.due));
                    chk(out_data == expect_word(e.d, e.l10), "R8 rebuilt word",
                        out_data, expect_word(e.d, e.l10));
                end
            end else if (rxq.size() > 0 && rxq[0].due <= ncnt) begin
                item_t e;
                e = rxq.pop_front();
                chk(1'b0, "R8 missing out_valid", W'(0), W'(1));
            end

            // transmit side
            if (act) begin
                j++;
                if (j == blen) act = 0;
            end
            if (io_sof) begin
                chk(!act, "R3 start strobe inside a word", W'(j), W'(blen));
                if (accq.size() == 0) begin
                    chk(1'b0, "R2 word sent without handshake", W'(1), W'(0));
                end else begin
                    item_t e;
                    cur  = accq.pop_front();
                    act  = 1;
                    j    = 0;
                    blen = cur.l10 ? BL_L : BL_S;
                    e    = cur;
                    e.due = ncnt + blen;
                    rxq.push_back(e);
                end
            end
            if (act) begin
                logic [NIO-1:0] ex;
                for (int k = 0; k < NIO; k++) ex[k] = cur.d[k*blen + j];
                chk(io_tx == ex, "R2 lane bit LSB first", W'(io_tx), W'(ex));
                chk(io_long == cur.l10, "R3 R4 R5 length flag", W'(io_long), W'(cur.l10));
                chk(io_sof == (j == 0), "R3 start strobe position", W'(io_sof), W'(j == 0));
                chk(in_ready == (j == blen - 1), "R6 ready in word", W'(in_ready), W'(j == blen - 1));
            end else begin
                chk(io_tx == '0 && !io_sof && !io_long, "R7 idle lines low",
                    W'({io_long, io_sof, io_tx}), W'(0));
                chk(in_ready, "R7 idle ready", W'(in_ready), W'(1));
            end
        end
        ncnt++;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] w;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(in_ready == 1'b1, "R1 ready in reset", W'(in_ready), W'(1));
        chk(io_tx == '0 && !io_sof && !io_long, "R1 lines in reset", W'({io_long, io_sof, io_tx}), W'(0));
        chk(!out_valid && out_data == '0, "R1 receiver in reset", out_data, W'(0));
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready && io_tx == '0 && !out_valid, "R1 after reset", W'({in_ready, io_tx}), W'(1) << NIO);
        repeat (3) @(posedge clk);
        #1;

        // R4 default 8-bit blocks, random word with dirty upper bits (R8 masking)
        send(rnd_word(), 1'b0);
        repeat (12) @(posedge clk);
        #1;
        // R4 10-bit blocks
        send(rnd_word(), 1'b1);
        repeat (14) @(posedge clk);
        #1;
        // walking one and all ones
        w = '0; w[5] = 1'b1;
        send(w, 1'b0);
        send({W{1'b1}}, 1'b1);
        // R6 back-to-back with mode changes at boundaries; R5 cfg moves mid-word
        send(rnd_word(), 1'b1);
        send(rnd_word(), 1'b0);
        send(rnd_word(), 1'b0);
        send(rnd_word(), 1'b1);
        // R5 toggle cfg while a short word is in flight and valid is low
        send(rnd_word(), 1'b0);
        cfg_long = 1'b1;
        repeat (3) @(posedge clk);
        #1 cfg_long = 1'b0;
        repeat (2) @(posedge clk);
        #1 cfg_long = 1'b1;
        repeat (12) @(posedge clk);
        #1;
        // R7 idle with changing data and valid low
        for (int i = 0; i < 6; i++) begin
            in_data = rnd_word();
            @(posedge clk);
            #1;
        end
        // burst of mixed words
        for (int i = 0; i < 20; i++) send(rnd_word(), 1'($urandom % 2));

        while (accq.size() > 0 || rxq.size() > 0 || act) @(posedge clk);
        repeat (4) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule